// File: doc/BRIEF.md
# Line Period and Half-Cycle Peak Detector

This block watches a stream of sampled, rectified line-voltage codes. It takes the timing of the AC line from that same sense path and needs no other signal. A timestamp is taken when the falling edge of each rectified half-wave passes through a window between a high threshold and a low threshold. The number of clock ticks between two successive timestamps is the half-cycle period. The block measures that period on every half-cycle, so it follows changes in line frequency while it runs.

With each period, the block reports the largest sample seen during the same half-cycle. A watchdog clears the valid flag when no timestamp arrives within a programmable number of clocks, which marks the line as lost. After a loss, measurement starts again from the beginning. A downstream compensation or control loop reads the period, the peak and the valid flag, and uses the strobes to know when new values arrive.

Top module: `line_period_peak`

## Requirements
- R1: While rst_n is low, and on the first clock after it, line_ok, period_stb and peak_stb are 0, and period_out and peak_out are 0.
- R2: A timestamp is taken for a valid sample only when the previous valid sample was above thr_hi and the current sample satisfies thr_lo < sample_code <= thr_hi. Cycles with sample_vld low change nothing.
- R3: On each timestamp except the first, period_out becomes the number of clocks between the capture edges of this stamping sample and the previous one. It is published with period_stb high for exactly one cycle, two clock edges after the stamping sample is captured.
- R4: The first timestamp after reset, or after a loss, only starts the measurement. It raises no strobe and leaves line_ok low. line_ok goes high together with the strobe of the second timestamp.
- R5: peak_out is the largest valid sample code from the sample after the previous stamping sample up to and including the current stamping sample. It is published with peak_stb in the same cycle as period_stb.
- R6: If more than timeout_lim clocks pass without a timestamp, line_ok is cleared, and the next timestamp counts as a first timestamp under R4.
- R7: If a sample falls from above thr_hi straight to at or below thr_lo, no timestamp is taken, and the arming is lost until a sample goes above thr_hi again.
- R8: Successive half-cycles with different lengths and different peaks each report their own period and peak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_vld | input | 1 | Sample strobe |
| sample_code | input | DATA_W | Unsigned rectified voltage code |
| thr_hi | input | DATA_W | Upper window threshold (arming level) |
| thr_lo | input | DATA_W | Lower window threshold |
| timeout_lim | input | CNT_W | Clocks without a timestamp before line loss |
| period_out | output | CNT_W | Latest half-cycle period in clocks |
| period_stb | output | 1 | One-cycle strobe: new period |
| peak_out | output | DATA_W | Peak code of the latest half-cycle |
| peak_stb | output | 1 | One-cycle strobe: new peak |
| line_ok | output | 1 | Measurement valid, line present |

## Verification
The bench drives rectified triangle half-waves of random length, sample spacing, amplitude and noise. A reference model predicts every period and peak, and an unexpected strobe counts as a failure. Directed cases cover each of the following, along with the fault a wrong design would show:
- A jump from above the window to below it. A design that armed on any sample in the window would add a spurious period.
- In-window codes held with the valid strobe low. A design that ignored the strobe would stamp early.
- The first timestamp after reset. A design that published the initial counter difference would raise an early, bogus strobe.
- A line loss. A design that did not restart would report one huge period and keep line_ok high.

// File: rtl/lpp_pkg.sv
// Shared helpers for the line period and peak detector.
// Assumes: all codes and counts are unsigned.
package lpp_pkg;
    // Default widths used by the top-level parameters.
    localparam int DEF_DATA_W = 12;
    localparam int DEF_CNT_W  = 24;

    // Phase of the window detector.
    typedef enum logic [0:0] {
        ARM_IDLE = 1'b0,
        ARM_HIGH = 1'b1
    } arm_state_e;
endpackage

// File: rtl/lpp_window_det.sv
// Window timestamp detector: fires one pulse when a valid sample falls
// from above thr_hi into the window (thr_lo, thr_hi].
// Assumes thr_hi > thr_lo. The pulse is registered, one clock after the capture edge.
module lpp_window_det #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_vld,
    input  logic [DATA_W-1:0] sample_code,
    input  logic [DATA_W-1:0] thr_hi,
    input  logic [DATA_W-1:0] thr_lo,
    output logic              stamp
);
    import lpp_pkg::*;

    arm_state_e arm_q;
    logic       above_hi;
    logic       in_window;

    // Classify the current sample against both thresholds.
    always_comb begin
        above_hi  = sample_code > thr_hi;
        in_window = (sample_code <= thr_hi) && (sample_code > thr_lo);
    end

    // Track whether the previous valid sample was above the window, and pulse on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= ARM_IDLE;
            stamp <= 1'b0;
        end else begin
            stamp <= 1'b0;
            if (sample_vld) begin
                stamp <= (arm_q == ARM_HIGH) && in_window;
                arm_q <= above_hi ? ARM_HIGH : ARM_IDLE;
            end
        end
    end
endmodule

// File: rtl/lpp_interval.sv
// Interval meter: free-running tick counter latched on each stamp; the
// difference from the previous latch is published with a one-cycle strobe.
// Assumes the counter wraps at most once per period (modular difference).
module lpp_interval #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stamp,
    input  logic             restart,
    output logic [CNT_W-1:0] period_out,
    output logic             period_stb
);
    logic [CNT_W-1:0] tick_q;
    logic [CNT_W-1:0] last_q;
    logic             started_q;

    // Free-running time base.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_q + 1'b1;
    end

    // Latch the time base on stamps and publish the difference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q     <= '0;
            started_q  <= 1'b0;
            period_out <= '0;
            period_stb <= 1'b0;
        end else begin
            period_stb <= 1'b0;
            if (restart) begin
                started_q <= 1'b0;
            end else if (stamp) begin
                last_q    <= tick_q;
                started_q <= 1'b1;
                if (started_q) begin
                    period_out <= tick_q - last_q;
                    period_stb <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lpp_peak_track.sv
// Half-cycle peak tracker: a running maximum over valid samples, moved to
// the output on each stamp and restarted for the next half-cycle.
// Assumes the stamp arrives one clock after its sample was captured.
module lpp_peak_track #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_vld,
    input  logic [DATA_W-1:0] sample_code,
    input  logic              stamp,
    input  logic              restart,
    output logic [DATA_W-1:0] peak_out,
    output logic              peak_stb
);
    logic [DATA_W-1:0] run_max_q;
    logic              primed_q;

    // Running maximum, reseeded on the stamp cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_max_q <= '0;
        end else if (stamp) begin
            run_max_q <= sample_vld ? sample_code : '0;
        end else if (sample_vld && (sample_code > run_max_q)) begin
            run_max_q <= sample_code;
        end
    end

    // Publish the captured peak once a full half-cycle is behind us.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
            peak_out <= '0;
            peak_stb <= 1'b0;
        end else begin
            peak_stb <= 1'b0;
            if (restart) begin
                primed_q <= 1'b0;
            end else if (stamp) begin
                primed_q <= 1'b1;
                if (primed_q) begin
                    peak_out <= run_max_q;
                    peak_stb <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lpp_watchdog.sv
// Line-loss watchdog: counts clocks since the last stamp (saturating),
// clears line_ok and requests a restart once the limit is exceeded.
// Sets line_ok on the second stamp after reset or loss.
module lpp_watchdog #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stamp,
    input  logic [CNT_W-1:0] timeout_lim,
    output logic             restart,
    output logic             line_ok
);
    localparam logic [CNT_W-1:0] GAP_MAX = '1;

    logic [CNT_W-1:0] gap_q;
    logic             primed_q;

    // Loss condition: too long since the last stamp.
    always_comb begin
        restart = !stamp && (gap_q >= timeout_lim);
    end

    // Saturating gap counter.
    always_ff @(posedge clk) begin
        if (!rst_n)               gap_q <= '0;
        else if (stamp)           gap_q <= '0;
        else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
    end

    // Valid flag and first-stamp tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
            line_ok  <= 1'b0;
        end else if (restart) begin
            primed_q <= 1'b0;
            line_ok  <= 1'b0;
        end else if (stamp) begin
            primed_q <= 1'b1;
            if (primed_q) line_ok <= 1'b1;
        end
    end
endmodule

// File: rtl/line_period_peak.sv
// Top: line half-cycle period and peak detector.
// Assumes thr_hi > thr_lo and that the rectified waveform falls through
// the window in at least one sample per half-cycle.
module line_period_peak #(
    parameter int DATA_W = lpp_pkg::DEF_DATA_W,
    parameter int CNT_W  = lpp_pkg::DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_vld,
    input  logic [DATA_W-1:0] sample_code,
    input  logic [DATA_W-1:0] thr_hi,
    input  logic [DATA_W-1:0] thr_lo,
    input  logic [CNT_W-1:0]  timeout_lim,
    output logic [CNT_W-1:0]  period_out,
    output logic              period_stb,
    output logic [DATA_W-1:0] peak_out,
    output logic              peak_stb,
    output logic              line_ok
);
    logic stamp_w;
    logic restart_w;

    lpp_window_det #(.DATA_W(DATA_W)) u_win (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
        .sample_code(sample_code), .thr_hi(thr_hi), .thr_lo(thr_lo),
        .stamp(stamp_w)
    );

    lpp_interval #(.CNT_W(CNT_W)) u_ivl (
        .clk(clk), .rst_n(rst_n), .stamp(stamp_w), .restart(restart_w),
        .period_out(period_out), .period_stb(period_stb)
    );

    lpp_peak_track #(.DATA_W(DATA_W)) u_pk (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
        .sample_code(sample_code), .stamp(stamp_w), .restart(restart_w),
        .peak_out(peak_out), .peak_stb(peak_stb)
    );

    lpp_watchdog #(.CNT_W(CNT_W)) u_wd (
        .clk(clk), .rst_n(rst_n), .stamp(stamp_w), .timeout_lim(timeout_lim),
        .restart(restart_w), .line_ok(line_ok)
    );
endmodule

// File: rtl/lpp_checker.sv
// Checker for line_period_peak: temporal properties on ports and the
// internal stamp and restart nets, attached by bind.
module lpp_checker (
    input logic clk,
    input logic rst_n,
    input logic sample_vld,
    input logic stamp,
    input logic restart,
    input logic period_stb,
    input logic peak_stb,
    input logic line_ok
);
    // R2
    stamp_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stamp |-> $past(sample_vld));

    // R3
    period_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_stb |=> !period_stb);

    // R3
    period_after_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_stb |-> $past(stamp));

    // R5
    peak_with_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_stb == peak_stb);

    // R4
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_ok) |-> period_stb);

    // R6
    valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_ok) |-> $past(restart));
endmodule

bind line_period_peak lpp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .stamp(stamp_w),
    .restart(restart_w), .period_stb(period_stb), .peak_stb(peak_stb),
    .line_ok(line_ok)
);

// File: tb/line_period_peak_tb.sv
module line_period_peak_tb;
    localparam int DW = 12;
    localparam int CW = 24;
    localparam int THI = 1500;
    localparam int TLO = 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sample_vld = 1'b0;
    logic [DW-1:0] sample_code = '0;
    logic [DW-1:0] thr_hi = DW'(THI);
    logic [DW-1:0] thr_lo = DW'(TLO);
    logic [CW-1:0] timeout_lim = CW'(100000);
    logic [CW-1:0] period_out;
    logic          period_stb;
    logic [DW-1:0] peak_out;
    logic          peak_stb;
    logic          line_ok;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int n_stb = 0;

    // reference model state
    bit m_armed = 0;
    bit m_started = 0;
    int m_last = 0;
    int m_runmax = 0;
    int q_per[$];
    int q_pk[$];

    line_period_peak #(.DATA_W(DW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
        .sample_code(sample_code), .thr_hi(thr_hi), .thr_lo(thr_lo),
        .timeout_lim(timeout_lim), .period_out(period_out),
        .period_stb(period_stb), .peak_out(peak_out), .peak_stb(peak_stb),
        .line_ok(line_ok)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int tri_val(input int i, input int n, input int pk);
        int h = n / 2;
        int d = (i < h) ? i : (n - 1 - i);
        return (pk * d) / h;
    endfunction

    // Drive one valid sample, update the model, then idle.
    task automatic send(input int code, input int idle);
        bit fire;
        @(negedge clk);
        sample_vld = 1'b1;
        sample_code = DW'(code);
        fire = m_armed && (code <= THI) && (code > TLO);
        if (code > m_runmax) m_runmax = code;
        if (fire) begin
            if (m_started) begin
                q_per.push_back(cyc - m_last);
                q_pk.push_back(m_runmax);
            end
            m_started = 1;
            m_last = cyc;
            m_runmax = 0;
        end
        m_armed = (code > THI);
        for (int k = 0; k < idle; k++) begin
            @(negedge clk);
            sample_vld = 1'b0;
        end
    endtask

    task automatic half_wave(input int n, input int sp, input int pk, input int noise);
        for (int i = 0; i < n; i++) begin
            int v = tri_val(i, n, pk);
            if (noise > 0) v = v + int'($urandom % (2 * noise + 1)) - noise;
            if (v < 0) v = 0;
            if (v > 4095) v = 4095;
            send(v, sp);
        end
    endtask

    // Monitor: every strobe must match the next model prediction.
    always @(negedge clk) begin
        if (rst_n && period_stb) begin
            n_stb++;
            if (q_per.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R2: actual unexpected strobe expected none");
            end else begin
                check("R3 period", int'(period_out), q_per.pop_front());
                check("R5 peak", int'(peak_out), q_pk.pop_front());
                check("R5 strobe pair", int'(peak_stb), 1);
            end
        end
    end

    initial begin
        #800000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int s0;
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        check("R1 line_ok", int'(line_ok), 0);
        check("R1 period_stb", int'(period_stb), 0);
        check("R1 peak_out", int'(peak_out), 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R1 period_out", int'(period_out), 0);
        check("R1 peak_stb", int'(peak_stb), 0);

        // R4: first timestamp only starts
        half_wave(40, 3, 3000, 0);
        repeat (4) @(negedge clk);
        check("R4 no strobe after first", n_stb, 0);
        check("R4 line_ok low after first", int'(line_ok), 0);
        half_wave(40, 3, 3200, 0);
        repeat (4) @(negedge clk);
        check("R4 strobe after second", n_stb, 1);
        check("R4 line_ok high", int'(line_ok), 1);

        // R7: jump over window, then in-window sample without arming
        s0 = n_stb;
        send(3000, 2); send(500, 2); send(1200, 2); send(1100, 4);
        repeat (4) @(negedge clk);
        check("R7 no stamp on jump", n_stb, s0);

        // R2: in-window code with sample_vld low is ignored
        send(3000, 1);
        @(negedge clk); sample_vld = 1'b0; sample_code = DW'(1200);
        repeat (6) @(negedge clk);
        check("R2 invalid sample ignored", n_stb, s0);
        send(2000, 2); send(1300, 3);
        repeat (4) @(negedge clk);
        check("R2 valid window sample stamps", n_stb, s0 + 1);

        // R8: random half-cycles of varying length, spacing, amplitude
        for (int h = 0; h < 150; h++) begin
            half_wave(20 + int'($urandom % 41), 1 + int'($urandom % 5),
                      1800 + int'($urandom % 2200), 15);
        end
        repeat (4) @(negedge clk);
        check("R8 all predicted strobes seen", q_per.size(), 0);

        // R6: line loss
        timeout_lim = CW'(300);
        repeat (100) @(negedge clk);
        check("R6 line_ok before timeout", int'(line_ok), 1);
        repeat (400) @(negedge clk);
        check("R6 line_ok cleared", int'(line_ok), 0);
        m_started = 0;
        s0 = n_stb;
        half_wave(40, 2, 3000, 0);
        repeat (4) @(negedge clk);
        check("R6 restart: no strobe on first", n_stb, s0);
        check("R6 restart: still invalid", int'(line_ok), 0);
        half_wave(40, 2, 2500, 0);
        repeat (4) @(negedge clk);
        check("R6 restart: valid again", int'(line_ok), 1);
        check("R3 queue drained", q_per.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule